// File: doc/BRIEF.md
# Floating-Point Issue Hazard Interlock

This block sits at the issue point of a pipeline that feeds several floating-point functional units. Each operation class has a fixed result latency and a fixed reuse interval. Every cycle the decode stage presents one candidate instruction: an operation class, a destination register and two source registers. The block then either lets it issue or holds it with a stall.

A stall is raised for three reasons:
- the class's unit has not yet reached its reuse interval (structural hazard);
- a source register still waits for a result in flight (read-after-write);
- an earlier write to the same destination would land no earlier than the new one (write-after-write).

Internally the block keeps one reuse countdown per functional unit and one pending-result countdown per architectural register. Every countdown falls by one on each clock. A per-register ready vector is brought out so that a checker or the register file can see which results are still outstanding.

Decode keeps the same instruction on the inputs while `stall` is high. It advances when `issue` pulses.

Top module: `fpil_issue_interlock`

## Requirements
- R1: After a synchronous active-high reset, every bit of `reg_ready` is 1, every unit is free, and an instruction presented in the first cycle of any class issues at once.
- R2: With `dec_valid` high, exactly one of `stall` and `issue` is high in that cycle, and `issue` is high exactly when no hazard holds. With `dec_valid` low, both are low and no state changes apart from the countdowns.
- R3: The class codes on `dec_cls` and their latency L and reuse interval I are:

  | Code | Class | L | I |
  |------|-------|---|---|
  | 0 | add/subtract | 4 | 3 |
  | 1 | multiply | 8 | 4 |
  | 2 | divide | 36 | 35 |
  | 3 | square root | 112 | 111 |
  | 4 | negate | 2 | 1 |
  | 5 | absolute value | 2 | 1 |
  | 6 | compare | 3 | 2 |
  | 7 | no-operation | – | – |

  Every class other than 7 writes its destination register.
- R4: An instruction of class c that issues at cycle t blocks a later instruction of the same class until cycle t+I. Each class owns its own unit, so different classes never block each other.
- R5: An instruction that issues at cycle t with latency L makes `reg_ready` of its destination low in cycles t+1 through t+L-1. An instruction that reads that register as a source stalls in those cycles.
- R6: Let P be the pending countdown of the destination register, which is 0 when the register is ready. A new instruction of latency L stalls when P is greater than or equal to L.
- R7: Classes 3, 4 and 5 read only `dec_src_a`. A pending result on `dec_src_b` does not stall them.
- R8: Class 7 issues in every cycle it is presented. It never stalls and leaves every countdown untouched.
- R9: Every nonzero countdown falls by exactly one per clock, whether the current instruction stalls or issues. An issue reloads the destination's countdown to L-1 and the unit's countdown to I-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A candidate instruction is present |
| dec_cls | input | 3 | Operation class code (see R3) |
| dec_dst | input | 5 | Destination register number |
| dec_src_a | input | 5 | First source register number |
| dec_src_b | input | 5 | Second source register number |
| stall | output | 1 | Candidate is held this cycle |
| issue | output | 1 | Candidate issues this cycle |
| reg_ready | output | 32 | Bit r is 1 when register r has no pending result |

## Verification
The bench runs a behavioural model alongside the block: integer countdowns per register and per class, compared against `stall`, `issue` and `reg_ready` on every clock.

Directed sequences target specific corner cases:
- A long divide followed by a short add to the same destination. A block with a reversed WAW comparison, or with none, would let the add retire first and then be overwritten by the stale divide result.
- Back-to-back multiplies and compares. An off-by-one in the reuse counter would show up as one cycle too many or too few of stall.
- A square root whose unused second source is pending, and a no-operation aimed at a pending register. A block that decodes sources or destinations without regard to class would stall, or disturb the countdowns, in those cases.

A long random stream over a small register pool then mixes all classes, so that structural, RAW and WAW conditions overlap.

// File: rtl/fpil_pkg.sv
package fpil_pkg;

    localparam int REG_W   = 5;
    localparam int NREG    = 1 << REG_W;
    localparam int CLS_W   = 3;
    localparam int CLASS_N = 1 << CLS_W;
    localparam int CNT_W   = 7;

    typedef enum logic [CLS_W-1:0] {
        CLS_ADD  = 3'd0,
        CLS_MUL  = 3'd1,
        CLS_DIV  = 3'd2,
        CLS_SQRT = 3'd3,
        CLS_NEG  = 3'd4,
        CLS_ABS  = 3'd5,
        CLS_CMP  = 3'd6,
        CLS_NOP  = 3'd7
    } fp_cls_e;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [REG_W-1:0] reg_idx_t;

    typedef struct packed {
        logic     valid;
        fp_cls_e  cls;
        reg_idx_t dst;
        reg_idx_t src_a;
        reg_idx_t src_b;
    } dec_req_t;

    typedef struct packed {
        logic structural;
        logic raw;
        logic waw;
    } hz_flags_t;

    function automatic cnt_t lat_of(fp_cls_e c);
        case (c)
            CLS_ADD:  return cnt_t'(4);
            CLS_MUL:  return cnt_t'(8);
            CLS_DIV:  return cnt_t'(36);
            CLS_SQRT: return cnt_t'(112);
            CLS_NEG:  return cnt_t'(2);
            CLS_ABS:  return cnt_t'(2);
            CLS_CMP:  return cnt_t'(3);
            default:  return cnt_t'(1);
        endcase
    endfunction

    function automatic cnt_t reuse_of(fp_cls_e c);
        case (c)
            CLS_ADD:  return cnt_t'(3);
            CLS_MUL:  return cnt_t'(4);
            CLS_DIV:  return cnt_t'(35);
            CLS_SQRT: return cnt_t'(111);
            CLS_NEG:  return cnt_t'(1);
            CLS_ABS:  return cnt_t'(1);
            CLS_CMP:  return cnt_t'(2);
            default:  return cnt_t'(1);
        endcase
    endfunction

    function automatic logic single_source(fp_cls_e c);
        return (c == CLS_SQRT) || (c == CLS_NEG) || (c == CLS_ABS);
    endfunction

    function automatic logic writes_dest(fp_cls_e c);
        return c != CLS_NOP;
    endfunction

endpackage

// File: rtl/fpil_unit_ctr.sv
module fpil_unit_ctr
    import fpil_pkg::*;
#(
    parameter int CW    = CNT_W,
    parameter int REUSE = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic busy
);

    localparam logic [CW-1:0] RELOAD = CW'(REUSE - 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (fire) begin
            remain <= RELOAD;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

    AST_UNIT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        fire |=> remain == RELOAD) else $error("unit reload");            // R9

    AST_UNIT_NO_REUSE: assert property (@(posedge clk) disable iff (rst)
        fire |-> remain == '0) else $error("unit reused early");          // R4

endmodule

// File: rtl/fpil_reg_table.sv
module fpil_reg_table
    import fpil_pkg::*;
#(
    parameter int N  = NREG,
    parameter int CW = CNT_W,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [CW-1:0] wr_val,
    output logic [CW-1:0] pend [N],
    output logic [N-1:0]  ready
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) pend[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (wr_en && (wr_idx == IW'(i))) begin
                    pend[i] <= wr_val;
                end else if (pend[i] != '0) begin
                    pend[i] <= pend[i] - 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_entry
        assign ready[g] = (pend[g] == '0);

        AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
            (!(wr_en && wr_idx == IW'(g)) && pend[g] != '0)
            |=> pend[g] == $past(pend[g]) - 1'b1) else $error("count step"); // R9

        AST_WAW_ORDER: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx == IW'(g)) |-> wr_val >= pend[g])
            else $error("write lands early");                             // R6
    end

endmodule

// File: rtl/fpil_hazard.sv
module fpil_hazard
    import fpil_pkg::*;
#(
    parameter int N  = NREG,
    parameter int CW = CNT_W
) (
    input  dec_req_t         req,
    input  logic [CLASS_N-1:0] unit_busy,
    input  logic [CW-1:0]    pend [N],
    output hz_flags_t        flags,
    output logic             hazard
);

    logic raw_a, raw_b;
    logic [CW-1:0] lat_new;

    always_comb begin
        lat_new = CW'(lat_of(req.cls));
        raw_a   = (pend[req.src_a] != '0);
        raw_b   = !single_source(req.cls) && (pend[req.src_b] != '0);
        if (!writes_dest(req.cls)) begin
            flags = '0;
        end else begin
            flags.structural = unit_busy[req.cls];
            flags.raw        = raw_a || raw_b;
            flags.waw        = (pend[req.dst] >= lat_new);
        end
        hazard = flags.structural || flags.raw || flags.waw;
    end

endmodule

// File: rtl/fpil_issue_interlock.sv
module fpil_issue_interlock
    import fpil_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    input  logic [CLS_W-1:0] dec_cls,
    input  logic [REG_W-1:0] dec_dst,
    input  logic [REG_W-1:0] dec_src_a,
    input  logic [REG_W-1:0] dec_src_b,
    output logic             stall,
    output logic             issue,
    output logic [NREG-1:0]  reg_ready
);

    dec_req_t            req;
    hz_flags_t           flags;
    logic                hazard;
    logic [CLASS_N-1:0]  unit_busy;
    logic [CLASS_N-1:0]  unit_fire;
    cnt_t                pend [NREG];
    logic                wr_en;
    cnt_t                wr_val;

    always_comb begin
        req.valid = dec_valid;
        req.cls   = fp_cls_e'(dec_cls);
        req.dst   = dec_dst;
        req.src_a = dec_src_a;
        req.src_b = dec_src_b;
    end

    fpil_hazard #(.N(NREG), .CW(CNT_W)) u_hazard (
        .req       (req),
        .unit_busy (unit_busy),
        .pend      (pend),
        .flags     (flags),
        .hazard    (hazard)
    );

    assign stall  = req.valid && hazard;
    assign issue  = req.valid && !hazard;
    assign wr_en  = issue && writes_dest(req.cls);
    assign wr_val = lat_of(req.cls) - 1'b1;

    for (genvar c = 0; c < CLASS_N; c++) begin : g_unit
        if (writes_dest(fp_cls_e'(c))) begin : g_real
            assign unit_fire[c] = issue && (req.cls == fp_cls_e'(c));
            fpil_unit_ctr #(
                .CW    (CNT_W),
                .REUSE (int'(reuse_of(fp_cls_e'(c))))
            ) u_ctr (
                .clk  (clk),
                .rst  (rst),
                .fire (unit_fire[c]),
                .busy (unit_busy[c])
            );
        end else begin : g_none
            assign unit_fire[c] = 1'b0;
            assign unit_busy[c] = 1'b0;
        end
    end

    fpil_reg_table #(.N(NREG), .CW(CNT_W)) u_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (req.dst),
        .wr_val (wr_val),
        .pend   (pend),
        .ready  (reg_ready)
    );

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (stall ^ issue)) else $error("outcome");            // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> (!stall && !issue)) else $error("idle");           // R2

    AST_RAW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (issue && writes_dest(req.cls)) |-> reg_ready[dec_src_a])
        else $error("raw");                                               // R5

    AST_NOP_FREE: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_cls == CLS_W'(CLS_NOP)) |-> issue)
        else $error("nop");                                               // R8

    AST_DEST_PENDING: assert property (@(posedge clk) disable iff (rst)
        (issue && writes_dest(req.cls)) |=> !reg_ready[$past(dec_dst)])
        else $error("dest");                                              // R5

endmodule

// File: tb/tb_fpil_issue_interlock.sv
module tb_fpil_issue_interlock;

    localparam int CLK_PERIOD = 10;
    localparam int NR = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dec_valid = 1'b0;
    logic [2:0]  dec_cls = 3'd0;
    logic [4:0]  dec_dst = 5'd0;
    logic [4:0]  dec_src_a = 5'd0;
    logic [4:0]  dec_src_b = 5'd0;
    logic        stall, issue;
    logic [NR-1:0] reg_ready;

    int n_vec = 0;
    int n_bad = 0;
    int rp [NR];
    int uc [7];
    int lat_t [7];
    int ii_t  [7];

    always #(CLK_PERIOD/2) clk = ~clk;

    fpil_issue_interlock dut (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_cls(dec_cls),
        .dec_dst(dec_dst), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .stall(stall), .issue(issue), .reg_ready(reg_ready)
    );

    task automatic chk(string tag, string what, longint act, longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit model_hazard(int c, int d, int a, int b);
        bit unary;
        if (c == 7) return 1'b0;
        unary = (c == 3) || (c == 4) || (c == 5);
        if (uc[c] != 0) return 1'b1;
        if (rp[a] != 0) return 1'b1;
        if (!unary && rp[b] != 0) return 1'b1;
        if (rp[d] >= lat_t[c]) return 1'b1;
        return 1'b0;
    endfunction

    // one cycle: drive at negedge, compare, then advance model at posedge
    task automatic step(string tag, bit v, int c, int d, int a, int b, output bit did);
        bit h, es, ei;
        logic [NR-1:0] er;
        @(negedge clk);
        dec_valid = v; dec_cls = 3'(c); dec_dst = 5'(d);
        dec_src_a = 5'(a); dec_src_b = 5'(b);
        #1;
        h  = model_hazard(c, d, a, b);
        es = v && h;
        ei = v && !h;
        for (int r = 0; r < NR; r++) er[r] = (rp[r] == 0);
        chk(tag, "stall", stall, es);
        chk(tag, "issue", issue, ei);
        chk(tag, "reg_ready", reg_ready, er);
        @(posedge clk);
        for (int r = 0; r < NR; r++) if (rp[r] > 0) rp[r]--;
        for (int u = 0; u < 7; u++) if (uc[u] > 0) uc[u]--;
        if (ei && c != 7) begin
            rp[d] = lat_t[c] - 1;
            uc[c] = ii_t[c] - 1;
        end
        did = ei;
    endtask

    task automatic send(string tag, int c, int d, int a, int b);
        bit did;
        for (int k = 0; k < 300; k++) begin
            step(tag, 1'b1, c, d, a, b, did);
            if (did) break;
        end
    endtask

    task automatic idle(string tag, int n);
        bit did;
        for (int k = 0; k < n; k++) step(tag, 1'b0, 0, 0, 0, 0, did);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        bit did;
        lat_t = '{4, 8, 36, 112, 2, 2, 3};
        ii_t  = '{3, 4, 35, 111, 1, 1, 2};
        for (int r = 0; r < NR; r++) rp[r] = 0;
        for (int u = 0; u < 7; u++) uc[u] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state, then first instruction issues at once
        idle("R1", 2);
        step("R1", 1'b1, 1, 1, 2, 3, did);
        chk("R1", "first issue", did, 1);

        // R3/R5: each class latency seen through a dependent read
        for (int c = 0; c < 7; c++) begin
            send("R3", c, 10 + c, 0, 0);
            send("R5", 0, 20, 10 + c, 0);
            idle("R3", 4);
        end
        idle("R3", 120);

        // R4: back-to-back same class, and different classes in parallel
        send("R4", 1, 1, 0, 0);
        send("R4", 1, 2, 0, 0);
        send("R4", 6, 3, 0, 0);
        send("R4", 6, 4, 0, 0);
        send("R4", 0, 5, 0, 0);
        step("R4", 1'b1, 4, 6, 0, 0, did);
        chk("R4", "neg beside add", did, 1);
        idle("R4", 12);

        // R6: long divide then short add to the same destination
        send("R6", 2, 7, 0, 0);
        send("R6", 0, 7, 0, 0);
        send("R6", 4, 8, 0, 0);
        send("R6", 1, 8, 0, 0);
        idle("R6", 40);

        // R7: single-source classes ignore pending second source
        send("R7", 1, 9, 0, 0);
        step("R7", 1'b1, 3, 11, 0, 9, did);
        chk("R7", "sqrt ignores src_b", did, 1);
        step("R7", 1'b1, 5, 12, 0, 9, did);
        chk("R7", "abs ignores src_b", did, 1);
        step("R7", 1'b1, 0, 13, 0, 9, did);
        chk("R7", "add honors src_b", did, 0);
        idle("R7", 10);

        // R8: no-operation aimed at pending registers
        send("R8", 0, 14, 0, 0);
        step("R8", 1'b1, 7, 14, 14, 14, did);
        chk("R8", "nop issues", did, 1);
        step("R8", 1'b1, 7, 14, 14, 14, did);
        idle("R8", 120);

        // R9/R2: random mixed stream over a small register pool
        for (int k = 0; k < 1500; k++) begin
            int c, d, a, b;
            c = int'($urandom_range(7, 0));
            d = int'($urandom_range(7, 0));
            a = int'($urandom_range(7, 0));
            b = int'($urandom_range(7, 0));
            if ($urandom_range(4, 0) == 0) step("R9", 1'b0, c, d, a, b, did);
            else send("R2", c, d, a, b);
        end
        idle("R9", 5);
        finish_run();
    end

endmodule